// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a 10-bit successive-approximation converter. A one-cycle start strobe carries a 4-bit channel address. The sequencer then builds a trial code one weight at a time, from the heaviest weight to the lightest. The trial code goes out to an external weighted DAC, and a 1-bit comparator answer comes back. After the last weight is decided, the code is copied into a result register and a one-cycle done pulse is raised.

Addresses 0 to 10 route the conversion to the external analog inputs. The channel number is presented on a port while the conversion runs. Three further addresses select internal reference points: the midpoint, the low end and the high end. For these the comparator port is ignored and each bit is decided against a fixed internal level, so each gives a known code. Addresses 14 and 15 are reserved: they convert the low reference and set a flag alongside the result. An abort drops the conversion in flight and leaves the result register untouched.

Top module: `sar_engine`

## Requirements
- R1: After reset, busy_o, done_o and rsv_o are 0, and result_o and trial_o are 0.
- R2: Step s (s = 9 down to 0) is the (10-s)-th cycle after the start edge. During step s, trial_o has bit s set, carries the already decided bits above s, and has zeros below s. The first step shows 0x200.
- R3: A step keeps its trial bit when the comparison reports input at or above the trial level (cmp_i = 1 for analog channels), and clears it otherwise.
- R4: A start strobe taken while idle sets busy_o on the next edge. done_o is high for exactly one cycle, 11 clock edges after the start edge. busy_o is low again in that same cycle.
- R5: For address 0 to 10, ext_chan_o equals the address and ext_act_o is 1 for the whole conversion. The result equals the ideal code of the comparator's input level.
- R6: Address 11 yields 0x200 whatever cmp_i does.
- R7: Address 12 yields 0x000 and address 13 yields 0x3FF, whatever cmp_i does. ext_act_o stays 0 for addresses 11 to 15.
- R8: Addresses 14 and 15 yield 0x000 and set rsv_o with the result. Any other completed conversion clears rsv_o.
- R9: An input level at or above full scale converts to 0x3FF, and a level of 0 converts to 0x000.
- R10: abort_i during a conversion (including its final load cycle) returns the block to idle on the next edge with no done pulse. result_o and rsv_o keep their previous values.
- R11: A start strobe while busy is ignored. The running conversion finishes with its original address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start strobe, taken only when idle |
| addr_i | input | 4 | Channel address sampled with start_i |
| abort_i | input | 1 | Cancel the conversion in flight |
| cmp_i | input | 1 | Comparator: 1 when input is at or above trial level |
| trial_o | output | 10 | Trial code to the weighted DAC (0 when idle) |
| ext_chan_o | output | 4 | Latched channel address |
| ext_act_o | output | 1 | An external analog channel is being converted |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when result_o is updated |
| result_o | output | 10 | Last completed conversion result |
| rsv_o | output | 1 | Last completed conversion used a reserved address |

## Verification
The assertions assume that start_i, abort_i and addr_i are synchronous to clk. They also assume that cmp_i settles within the cycle from the trial_o value shown in that cycle, as an ideal comparator in front of a DAC would. The bench changes every input half a period away from the rising edge. It derives cmp_i combinationally from trial_o and a per-channel integer level, and it toggles cmp_i randomly when a self-test address is in use. Levels include 0, 1, 511, 512, 1023 and values past full scale. Aborts land on the first step, middle steps, the last step and the load cycle.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int unsigned SAR_RES_W  = 10;
  localparam int unsigned SAR_ADDR_W = 4;
  localparam int unsigned SAR_N_EXT  = 11;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RESOLVE = 2'd1,
    ST_LOAD    = 2'd2
  } sar_state_e;
endpackage

// File: rtl/sar_chan_dec.sv
module sar_chan_dec #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned RES_W  = 10,
  parameter int unsigned N_EXT  = 11
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              is_ext_o,
  output logic              is_rsv_o,
  output logic [RES_W-1:0]  ref_lvl_o
);
  localparam logic [ADDR_W-1:0] A_MID  = ADDR_W'(N_EXT);
  localparam logic [ADDR_W-1:0] A_LOW  = ADDR_W'(N_EXT + 1);
  localparam logic [ADDR_W-1:0] A_HIGH = ADDR_W'(N_EXT + 2);
  localparam logic [RES_W-1:0]  LVL_MID  = {1'b1, {(RES_W-1){1'b0}}};
  localparam logic [RES_W-1:0]  LVL_LOW  = '0;
  localparam logic [RES_W-1:0]  LVL_HIGH = '1;

  always_comb begin
    is_ext_o  = 1'b0;
    is_rsv_o  = 1'b0;
    ref_lvl_o = LVL_LOW;
    if (addr_i < A_MID) begin
      is_ext_o = 1'b1;
    end else if (addr_i == A_MID) begin
      ref_lvl_o = LVL_MID;
    end else if (addr_i == A_LOW) begin
      ref_lvl_o = LVL_LOW;
    end else if (addr_i == A_HIGH) begin
      ref_lvl_o = LVL_HIGH;
    end else begin
      is_rsv_o = 1'b1;
    end
  end
endmodule

// File: rtl/sar_core.sv
module sar_core #(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             keep_i,
  output logic [RES_W-1:0] code_o,
  output logic             last_o
);
  localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] code_q, code_d;
  logic [RES_W-1:0] probe_q, probe_d;
  logic             en;

  always_comb begin
    code_d  = code_q;
    probe_d = probe_q;
    if (load_i) begin
      code_d  = TOP_BIT;
      probe_d = TOP_BIT;
    end else if (step_i) begin
      code_d  = (keep_i ? code_q : (code_q & ~probe_q)) | (probe_q >> 1);
      probe_d = probe_q >> 1;
    end
  end

  assign en = load_i | step_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      probe_q <= '0;
    end else if (en) begin
      code_q  <= code_d;
      probe_q <= probe_d;
    end
  end

  assign code_o = code_q;
  assign last_o = probe_q[0];
endmodule

// File: rtl/sar_engine.sv
module sar_engine
  import sar_pkg::*;
#(
  parameter int unsigned RES_W  = SAR_RES_W,
  parameter int unsigned ADDR_W = SAR_ADDR_W,
  parameter int unsigned N_EXT  = SAR_N_EXT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              abort_i,
  input  logic              cmp_i,
  output logic [RES_W-1:0]  trial_o,
  output logic [ADDR_W-1:0] ext_chan_o,
  output logic              ext_act_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [RES_W-1:0]  result_o,
  output logic              rsv_o
);
  sar_state_e        state_q, state_d;
  logic [ADDR_W-1:0] chan_q, chan_d;
  logic [RES_W-1:0]  res_q, res_d;
  logic              rsv_q, rsv_d;
  logic              done_q, done_d;
  logic              core_load, core_step, keep, last;
  logic              is_ext, is_rsv;
  logic [RES_W-1:0]  ref_lvl, code;
  logic              chan_en, res_en;

  sar_chan_dec #(.ADDR_W(ADDR_W), .RES_W(RES_W), .N_EXT(N_EXT)) u_dec (
    .addr_i   (chan_q),
    .is_ext_o (is_ext),
    .is_rsv_o (is_rsv),
    .ref_lvl_o(ref_lvl)
  );

  sar_core #(.RES_W(RES_W)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(core_load),
    .step_i(core_step),
    .keep_i(keep),
    .code_o(code),
    .last_o(last)
  );

  // analog channels trust the comparator; self-test points use a fixed level
  assign keep = is_ext ? cmp_i : (ref_lvl >= code);

  always_comb begin
    state_d   = state_q;
    chan_d    = chan_q;
    res_d     = res_q;
    rsv_d     = rsv_q;
    done_d    = 1'b0;
    core_load = 1'b0;
    core_step = 1'b0;
    chan_en   = 1'b0;
    res_en    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i && !abort_i) begin
          state_d   = ST_RESOLVE;
          chan_d    = addr_i;
          chan_en   = 1'b1;
          core_load = 1'b1;
        end
      end
      ST_RESOLVE: begin
        if (abort_i) begin
          state_d = ST_IDLE;
        end else begin
          core_step = 1'b1;
          if (last) state_d = ST_LOAD;
        end
      end
      ST_LOAD: begin
        state_d = ST_IDLE;
        if (!abort_i) begin
          res_d  = code;
          rsv_d  = is_rsv;
          res_en = 1'b1;
          done_d = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
    end else if (chan_en) begin
      chan_q <= chan_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      rsv_q <= 1'b0;
    end else if (res_en) begin
      res_q <= res_d;
      rsv_q <= rsv_d;
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign trial_o    = busy_o ? code : '0;
  assign ext_chan_o = chan_q;
  assign ext_act_o  = busy_o && is_ext;
  assign done_o     = done_q;
  assign result_o   = res_q;
  assign rsv_o      = rsv_q;
endmodule

// File: rtl/sar_engine_chk.sv
module sar_engine_chk #(
  parameter int unsigned RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_o,
  input logic             done_o,
  input logic [RES_W-1:0] result_o,
  input logic [RES_W-1:0] trial_o,
  input logic             rsv_o
);
  localparam logic [RES_W-1:0] FIRST_TRIAL = {1'b1, {(RES_W-1){1'b0}}};

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_after_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(busy_o) && !busy_o));

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));

  assert_first_trial_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !$past(busy_o)) |-> (trial_o == FIRST_TRIAL));

  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_o |-> (result_o == '0));
endmodule

bind sar_engine sar_engine_chk #(.RES_W(RES_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .result_o(result_o),
  .trial_o (trial_o),
  .rsv_o   (rsv_o)
);

// File: tb/tb_sar_engine.sv
module tb_sar_engine;
  localparam int CLK_P = 10;

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic [3:0] addr_i;
  logic       abort_i;
  logic       cmp_i;
  logic [9:0] trial_o;
  logic [3:0] ext_chan_o;
  logic       ext_act_o;
  logic       busy_o;
  logic       done_o;
  logic [9:0] result_o;
  logic       rsv_o;

  int  total = 0;
  int  bad   = 0;
  int  vin [0:10];
  logic junk;

  sar_engine dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .abort_i(abort_i), .cmp_i(cmp_i), .trial_o(trial_o),
    .ext_chan_o(ext_chan_o), .ext_act_o(ext_act_o), .busy_o(busy_o),
    .done_o(done_o), .result_o(result_o), .rsv_o(rsv_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // ideal comparator; noise when a self-test point is selected
  always_comb begin
    if (ext_act_o && ext_chan_o < 4'd11)
      cmp_i = (vin[ext_chan_o] >= int'(trial_o));
    else
      cmp_i = junk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_code(input logic [3:0] a);
    if (a < 4'd11) begin
      if (vin[a] >= 1023) return 1023;
      if (vin[a] <= 0) return 0;
      return vin[a];
    end
    if (a == 4'd11) return 512;
    if (a == 4'd13) return 1023;
    return 0;
  endfunction

  function automatic int exp_trial(input int code, input int s);
    return ((code >> (s + 1)) << (s + 1)) | (1 << s);
  endfunction

  // abort_at: -1 none, else negedge index k (0..10) where abort is raised
  task automatic convert(input logic [3:0] a, input int abort_at, input bit poke);
    int  ec;
    int  prev_res;
    bit  prev_rsv;
    ec       = exp_code(a);
    prev_res = int'(result_o);
    prev_rsv = rsv_o;
    start_i = 1'b1;
    addr_i  = a;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k <= 10; k++) begin
      junk = 1'($urandom);
      chk(busy_o == 1'b1, "R4 busy", int'(busy_o), 1);
      chk(done_o == 1'b0, "R4 early done", int'(done_o), 0);
      if (k <= 9)
        chk(int'(trial_o) == exp_trial(ec, 9 - k), "R2/R3 trial", int'(trial_o), exp_trial(ec, 9 - k));
      if (a < 4'd11) begin
        chk(ext_act_o && ext_chan_o == a, "R5 channel", int'(ext_chan_o), int'(a));
      end else begin
        chk(ext_act_o == 1'b0, "R7 ext_act", int'(ext_act_o), 0);
      end
      if (k == abort_at) begin
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        chk(busy_o == 1'b0, "R10 idle", int'(busy_o), 0);
        chk(done_o == 1'b0, "R10 no done", int'(done_o), 0);
        chk(int'(result_o) == prev_res, "R10 result kept", int'(result_o), prev_res);
        chk(rsv_o == prev_rsv, "R10 rsv kept", int'(rsv_o), int'(prev_rsv));
        @(negedge clk);
        chk(done_o == 1'b0 && int'(result_o) == prev_res, "R10 still held", int'(result_o), prev_res);
        return;
      end
      if (poke && k == 3) begin
        start_i = 1'b1;
        addr_i  = ~a;
        @(negedge clk);
        start_i = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    chk(done_o == 1'b1, "R4 done", int'(done_o), 1);
    chk(busy_o == 1'b0, "R4 busy drop", int'(busy_o), 0);
    chk(int'(result_o) == ec, poke ? "R11 result" : "R5/R6/R7/R9 result", int'(result_o), ec);
    chk(rsv_o == (a >= 4'd14), "R8 rsv", int'(rsv_o), int'(a >= 4'd14));
    @(negedge clk);
    chk(done_o == 1'b0, "R4 pulse width", int'(done_o), 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unused;
    unused  = $urandom(32'd4242);
    rst_n   = 1'b0;
    start_i = 1'b0;
    addr_i  = '0;
    abort_i = 1'b0;
    junk    = 1'b0;
    for (int i = 0; i < 11; i++) vin[i] = int'($urandom_range(0, 1100));
    vin[0] = 0; vin[1] = 1023; vin[2] = 1100;
    vin[3] = 512; vin[4] = 511; vin[5] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o == 0 && done_o == 0 && rsv_o == 0, "R1 flags", int'({busy_o, done_o, rsv_o}), 0);
    chk(result_o == 0 && trial_o == 0, "R1 data", int'(result_o), 0);

    convert(4'd11, -1, 1'b0);   // R6
    convert(4'd12, -1, 1'b0);   // R7
    convert(4'd13, -1, 1'b0);   // R7
    convert(4'd14, -1, 1'b0);   // R8
    convert(4'd3,  -1, 1'b0);   // R8 clear, R5
    convert(4'd15, -1, 1'b0);   // R8
    convert(4'd0,  -1, 1'b0);   // R9 zero
    convert(4'd1,  -1, 1'b0);   // R9 full scale
    convert(4'd2,  -1, 1'b0);   // R9 above full scale
    convert(4'd4,  -1, 1'b0);
    convert(4'd5,  -1, 1'b0);
    convert(4'd13,  0, 1'b0);   // R10 first step
    convert(4'd11,  5, 1'b0);   // R10 mid
    convert(4'd1,   9, 1'b0);   // R10 last step
    convert(4'd14, 10, 1'b0);   // R10 load cycle
    convert(4'd6,  -1, 1'b1);   // R11

    for (int n = 0; n < 60; n++) begin
      logic [3:0] a;
      int ab;
      a  = 4'($urandom_range(0, 15));
      ab = ($urandom_range(0, 4) == 0) ? int'($urandom_range(0, 10)) : -1;
      convert(a, ab, ($urandom_range(0, 4) == 0));
      if ($urandom_range(0, 2) == 0) @(negedge clk);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule